// File: doc/BRIEF.md
# Banked Nonvolatile Register Store with Write-Busy Status

This block holds the persistent settings that sit next to a digitally set wiper: sixteen bytes split into four banks of four registers. A command controller sends it one request per cycle: read a register, write a register, copy a register into the wiper, or save the present wiper value into a register. Reads and wiper loads come back on the cycle after the request. A write or wiper save is a slow nonvolatile operation. It is modelled as a busy interval of `BUSY_CYCLES` clocks. A busy flag that the controller can only read stays high for the whole interval, and the stored byte changes when that interval ends.

The write-protect input is checked in this block. While it is low, every write and save is refused. A write or save that arrives while a previous one is still busy is also refused. Each refusal raises a one-cycle error pulse and leaves the contents as they were. Reads and wiper loads are always served, including during a busy interval. The register at bank 0, index 0 is brought out at all times as the default wiper value that is used at power-up.

Top module: `nvr_bank_store`

## Requirements
- R1: After reset, busy, err, rd_valid and ld_valid are 0, and every register holds INIT_VAL (0x80 by default).
- R2: A read request (op code 2'b00) gives rd_valid=1 and rd_data equal to the register selected by {bank, reg} on the cycle after the request.
- R3: An accepted write (op code 2'b01) raises busy on the cycle after the request. Busy stays high for exactly BUSY_CYCLES cycles. The register takes the new value on the edge where busy falls.
- R4: While busy is high, reads are served and return the contents from before the pending write, including at the address being written.
- R5: A write or save request made while busy is high is refused. The block gives one err pulse on the next cycle, busy is not restarted, and no register changes.
- R6: A write or save request made while wp_n is low is refused. The block gives one err pulse, busy stays low, and no register changes.
- R7: A load request (op code 2'b10) gives ld_valid=1 and ld_data equal to the selected register on the next cycle. This works during busy and while wp_n is low.
- R8: A save request (op code 2'b11) stores the value that wiper_in had in the request cycle. Later changes on wiper_in have no effect on the stored value.
- R9: default_val always shows the register at bank 0, index 0. It changes only on the edge where a busy interval ends.
- R10: A write changes only the register it addresses. The other fifteen registers keep their values, and the values 0x00 and 0xFF are stored exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 00 read, 01 write, 10 load wiper, 11 save wiper |
| req_bank | input | BANK_W | Bank select |
| req_reg | input | REG_W | Register select within the bank |
| req_data | input | DW | Data for a write |
| wiper_in | input | DW | Present wiper value, used by a save |
| wp_n | input | 1 | Write enable; low refuses writes and saves |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW | Read result |
| ld_valid | output | 1 | Wiper load valid |
| ld_data | output | DW | Value to load into the wiper |
| err | output | 1 | One-cycle pulse for a refused write or save |
| busy | output | 1 | Nonvolatile write in progress |
| default_val | output | DW | Power-up wiper value (bank 0, index 0) |

## Verification
The bench reads the register under write while the write is still pending. A design that commits at acceptance returns the new value too early. It then tries a write and a save during the busy interval. A design that restarts the timer or overwrites the pending data either shows no err pulse or makes the busy run longer than BUSY_CYCLES. It changes wiper_in after a save is accepted, which catches a design that samples the wiper at commit time. It also checks that default_val holds its old value until busy falls, and that a refused write with write protect low leaves busy low and the target register unchanged.

// File: rtl/nvr_pkg.sv
package nvr_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LOAD  = 2'b10,
        OP_SAVE  = 2'b11
    } nvr_op_e;
endpackage

// File: rtl/nvr_busy_timer.sv
module nvr_busy_timer #(
    parameter int CYCLES = 1000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);
endmodule

// File: rtl/nvr_cell_array.sv
module nvr_cell_array #(
    parameter int ENTRIES = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] INIT_VAL = 8'h80,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] dflt_data
);
    logic [DW-1:0] cell_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        logic [DW-1:0] cell_d;
        always_comb begin
            cell_d = cell_q[i];
            if (wr_en && (wr_idx == IW'(i))) cell_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) cell_q[i] <= INIT_VAL;
            else        cell_q[i] <= cell_d;
        end
    end

    assign rd_data   = cell_q[rd_idx];
    assign dflt_data = cell_q[0];
endmodule

// File: rtl/nvr_bank_store.sv
module nvr_bank_store
    import nvr_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int REGS = 4,
    parameter int DW = 8,
    parameter int BUSY_CYCLES = 1000,
    parameter logic [DW-1:0] INIT_VAL = 8'h80,
    localparam int BANK_W = $clog2(BANKS),
    localparam int REG_W = $clog2(REGS),
    localparam int ENTRIES = BANKS * REGS,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DW-1:0]     req_data,
    input  logic [DW-1:0]     wiper_in,
    input  logic              wp_n,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              ld_valid,
    output logic [DW-1:0]     ld_data,
    output logic              err,
    output logic              busy,
    output logic [DW-1:0]     default_val
);
    typedef struct packed {
        logic          rd_valid;
        logic [DW-1:0] rd_data;
        logic          ld_valid;
        logic [DW-1:0] ld_data;
        logic          err;
        logic [IW-1:0] pend_idx;
        logic [DW-1:0] pend_data;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          start, done;
    logic [IW-1:0] req_idx;
    logic [DW-1:0] cell_rd;
    nvr_op_e       op;

    // REGS is a power of two, so bank and register concatenate into the index
    assign req_idx = {req_bank, req_reg};
    assign op      = nvr_op_e'(req_op);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.ld_valid = 1'b0;
        ctl_d.err      = 1'b0;
        start          = 1'b0;
        if (req_valid) begin
            unique case (op)
                OP_READ: begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = cell_rd;
                end
                OP_LOAD: begin
                    ctl_d.ld_valid = 1'b1;
                    ctl_d.ld_data  = cell_rd;
                end
                OP_WRITE, OP_SAVE: begin
                    if (busy || !wp_n) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        start           = 1'b1;
                        ctl_d.pend_idx  = req_idx;
                        ctl_d.pend_data = (op == OP_SAVE) ? wiper_in : req_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    nvr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    nvr_cell_array #(.ENTRIES(ENTRIES), .DW(DW), .INIT_VAL(INIT_VAL)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (done),
        .wr_idx    (ctl_q.pend_idx),
        .wr_data   (ctl_q.pend_data),
        .rd_idx    (req_idx),
        .rd_data   (cell_rd),
        .dflt_data (default_val)
    );

    assign rd_valid = ctl_q.rd_valid;
    assign rd_data  = ctl_q.rd_data;
    assign ld_valid = ctl_q.ld_valid;
    assign ld_data  = ctl_q.ld_data;
    assign err      = ctl_q.err;
endmodule

// File: rtl/nvr_store_checker.sv
module nvr_store_checker #(
    parameter int BUSY_CYCLES = 1000,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          wp_n,
    input logic          rd_valid,
    input logic          ld_valid,
    input logic          err,
    input logic          busy,
    input logic [DW-1:0] default_val
);
    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R2: a read result only follows a read request
    assert_rd_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_op == 2'b00));

    // R7: a wiper load only follows a load request
    assert_ld_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && req_op == 2'b10));

    // R3: busy starts only from a permitted write or save request
    assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_op[0] && wp_n));

    // R3: each busy interval lasts exactly BUSY_CYCLES cycles
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == BUSY_CYCLES));

    // R5: an error pulse only follows a write or save request
    assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && req_op[0]));

    // R6: with write protect active, no busy interval begins
    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wp_n) && !$past(busy)) |-> !busy);

    // R9: the default value moves only when a busy interval ends
    assert_default_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(default_val) |-> $fell(busy));
endmodule

bind nvr_bank_store nvr_store_checker #(.BUSY_CYCLES(BUSY_CYCLES), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .wp_n        (wp_n),
    .rd_valid    (rd_valid),
    .ld_valid    (ld_valid),
    .err         (err),
    .busy        (busy),
    .default_val (default_val)
);

// File: tb/nvr_bank_store_test.sv
`timescale 1ns/1ps
module nvr_bank_store_test;
    localparam int BUSY = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [1:0] req_bank = '0;
    logic [1:0] req_reg = '0;
    logic [7:0] req_data = '0;
    logic [7:0] wiper_in = '0;
    logic       wp_n = 1'b1;
    logic       rd_valid, ld_valid, err, busy;
    logic [7:0] rd_data, ld_data, default_val;

    always #2 clk = ~clk;

    nvr_bank_store #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_reg(req_reg), .req_data(req_data),
        .wiper_in(wiper_in), .wp_n(wp_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .ld_valid(ld_valid), .ld_data(ld_data), .err(err), .busy(busy),
        .default_val(default_val)
    );

    typedef struct {
        int         kind;   // 0 read, 1 load, 2 err
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] model [16];
    int         total = 0;
    int         bad = 0;
    int         run = 0;
    int         last_run = 0;
    bit         ended = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: compare every result pulse with the scoreboard front
    always @(negedge clk) begin
        if (rst_n && (rd_valid || ld_valid || err)) begin
            int   k;
            logic [7:0] v;
            exp_t e;
            k = err ? 2 : (ld_valid ? 1 : 0);
            v = ld_valid ? ld_data : rd_data;
            if (sb.size() == 0) begin
                check(0, "unexpected result", k, -1);
            end else begin
                e = sb.pop_front();
                if (e.kind == 2) check(k == 2, e.tag, k, 2);
                else check(k == e.kind && v == e.val, e.tag, {k, v}, {e.kind, e.val});
            end
        end
        if (busy) run++;
        else if (run > 0) begin
            last_run = run;
            run = 0;
        end
    end

    task automatic issue(input logic [1:0] op, input int b, input int r, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank = 2'(b); req_reg = 2'(r); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input int b, input int r, input string tag);
        sb.push_back('{0, model[b*4+r], tag});
        issue(2'b00, b, r, 8'h00);
    endtask

    task automatic do_load(input int b, input int r, input string tag);
        sb.push_back('{1, model[b*4+r], tag});
        issue(2'b10, b, r, 8'h00);
    endtask

    task automatic do_refused(input logic [1:0] op, input int b, input int r, input string tag);
        sb.push_back('{2, 8'h00, tag});
        issue(op, b, r, 8'hEE);
    endtask

    task automatic wait_idle(input int idx, input logic [7:0] v, input string tag);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(last_run == BUSY, tag, last_run, BUSY);
        model[idx] = v;
    endtask

    task automatic write_commit(input int b, input int r, input logic [7:0] d, input string tag);
        issue(2'b01, b, r, d);
        check(busy == 1'b1, tag, busy, 1);
        wait_idle(b*4+r, d, tag);
    endtask

    initial begin
        #800000;
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!busy && !err && !rd_valid && !ld_valid, "R1 reset flags", {busy, err, rd_valid, ld_valid}, 0);
        check(default_val == 8'h80, "R1 reset default", default_val, 8'h80);
        for (int i = 0; i < 16; i++) do_read(i / 4, i % 4, "R1 R2 reset contents");

        // R3 R4 R5 R7: write with activity during busy
        issue(2'b01, 1, 2, 8'h5A);
        check(busy == 1'b1, "R3 busy after write", busy, 1);
        do_read(1, 2, "R4 old value during busy");
        do_refused(2'b01, 2, 1, "R5 write during busy");
        do_refused(2'b11, 3, 0, "R5 save during busy");
        do_load(1, 2, "R7 load during busy");
        wait_idle(6, 8'h5A, "R3 busy length");
        do_read(1, 2, "R3 committed value");
        do_read(2, 1, "R5 refused write left target");
        do_read(3, 0, "R5 refused save left target");

        // R6: write protect
        wp_n = 1'b0;
        do_refused(2'b01, 2, 2, "R6 write under protect");
        check(busy == 1'b0, "R6 busy stays low", busy, 0);
        do_refused(2'b11, 2, 2, "R6 save under protect");
        check(busy == 1'b0, "R6 busy stays low after save", busy, 0);
        do_load(1, 2, "R7 load under protect");
        wp_n = 1'b1;
        do_read(2, 2, "R6 target unchanged");

        // R8: save captures wiper at request
        wiper_in = 8'h33;
        issue(2'b11, 3, 3, 8'h00);
        wiper_in = 8'hC4;
        wait_idle(15, 8'h33, "R8 save busy length");
        do_read(3, 3, "R8 saved wiper value");
        do_load(3, 3, "R8 R7 load saved value");

        // R9: default value follows bank 0 index 0 at end of busy
        issue(2'b01, 0, 0, 8'hC7);
        check(default_val == 8'h80, "R9 default holds during busy", default_val, 8'h80);
        wait_idle(0, 8'hC7, "R9 busy length");
        check(default_val == 8'hC7, "R9 default after commit", default_val, 8'hC7);

        // R10: isolation and boundary values
        write_commit(2, 3, 8'h00, "R10 write zero");
        write_commit(1, 0, 8'hFF, "R10 write ff");
        write_commit(3, 1, 8'h01, "R10 write one");
        for (int i = 0; i < 16; i++) do_read(i / 4, i % 4, "R10 full readback");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "missing results", sb.size(), 0);
        summary();
    end
endmodule